// File: doc/BRIEF.md
# Power-Management Event Status, Enable and SCI Generator

This block is the event half of a power-management function. A small configuration space holds the base and the enable for a 64-byte I/O window. That window can be moved anywhere on a 64-byte boundary. Inside the window are a 16-bit event status register, a 16-bit event enable register and a free-running power-management timer.

Event pulses from the rest of the chip set status bits. Software clears a status bit by writing a one to it. A single level interrupt output (SCI) is high while any of four qualified sources is both flagged and enabled: the timer, the global lock, the power button and the RTC alarm.

A second registered output tells the timer scheduler whether a timer-overflow event is currently armed. It is armed only while the timer enable is set and the timer status is still clear. All reads are registered and return one cycle after the strobe.

Top module: `pm_evt_sci`

## Requirements
- R1: After synchronous reset, configuration dword 0x04 reads 0, dword 0x48 reads 0x00000001, dwords 0x40 and 0x80 read 0, and both `sci` and `tmr_arm` are 0.
- R2: An I/O access hits the window when configuration byte 0x80 bit 0 is 1 and `io_addr[15:6]` equals bits 15:6 of configuration dword 0x40. Bits 5:0 and 31:16 of that dword take no part in the decode.
- R3: An I/O read that misses the window, or any I/O read while the window is disabled, returns 16'hFFFF. A write in either case changes no register.
- R4: Within the window the layout is fixed, with `io_addr[0]` ignored:
  - offset 0 is the status register;
  - offset 2 is the enable register;
  - offset 8 returns timer bits 15:0;
  - offset 10 returns the timer zero-extended to 32 bits, bits 31:16;
  - every other offset reads 0.
- R5: A one-cycle pulse on `ev_in[i]` sets status bit i. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. When a set and a clear meet on the same edge, the set wins.
- R6: All 16 enable bits are read/write and read back exactly as written.
- R7: `sci` is registered and is 1 exactly when (status AND enable) is non-zero in any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC). It follows the edge at which the status or enable register changes.
- R8: Status and enable bits outside the set {0, 5, 8, 10} never drive `sci` high.
- R9: The timer is a TMR_W-bit counter that increments on every clock and wraps. Status bit 0 sets on the edge after the timer's top bit changes value.
- R10: `tmr_arm` is registered and equals enable bit 0 AND NOT status bit 0, updated on the same edge as those registers.
- R11: `cfg_rdata` and `io_rdata` hold the value addressed on the edge where the read strobe was sampled. Unmapped configuration dwords read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration dword write strobe |
| cfg_rd | input | 1 | Configuration dword read strobe |
| cfg_addr | input | 8 | Configuration byte address (dword aligned) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| io_wr | input | 1 | I/O 16-bit write strobe |
| io_rd | input | 1 | I/O 16-bit read strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | Registered I/O read data |
| ev_in | input | 16 | Event set pulses, one per status bit |
| sci | output | 1 | Level system control interrupt |
| tmr_arm | output | 1 | Timer-overflow event armed |

## Verification
The bench relocates the window to a base whose low six bits are nonzero. A decoder that forgets to mask those bits would then miss its own registers and read all ones. It probes the bytes just below and just above the window, and it writes while the window is disabled. A decoder off by one, or one that ignores the enable, would either corrupt the enable register or return data instead of all ones. It pulses a status bit outside the qualified set while that bit is enabled, which catches an interrupt built from the full AND. It also collides an event with a write-1-to-clear of the same bit, which catches a design that lets the clear win and loses the event. Finally, it waits for a real timer overflow and checks that arming drops while the status is set and returns once it is cleared.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int PM1_W = 16;

  // Bit positions of the four interrupt-qualified sources
  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;

  localparam logic [PM1_W-1:0] SCI_MASK =
    (PM1_W'(1) << BIT_TMR) | (PM1_W'(1) << BIT_GBL) |
    (PM1_W'(1) << BIT_PWR) | (PM1_W'(1) << BIT_RTC);

  // Word indices inside the window (byte offset / 2)
  localparam int WI_STS = 0;
  localparam int WI_EN  = 1;
  localparam int WI_TLO = 4;
  localparam int WI_THI = 5;

  // Configuration dword addresses
  localparam logic [7:0] CA_CMD  = 8'h04;
  localparam logic [7:0] CA_BASE = 8'h40;
  localparam logic [7:0] CA_IOB2 = 8'h48;
  localparam logic [7:0] CA_WCTL = 8'h80;

  localparam logic [31:0] RST_IOB2 = 32'h0000_0001;
  localparam logic [15:0] MISS_DATA = 16'hFFFF;
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_evt_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int IO_AW  = 16,
  parameter int WIN_AW = 6,
  localparam int SEL_W = IO_AW - WIN_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [SEL_W-1:0]  base_sel,
  output logic              win_en
);
  logic [31:0] cmd_q, base_q, iob2_q;
  logic [7:0]  wctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      base_q <= '0;
      iob2_q <= RST_IOB2;
      wctl_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == CFG_AW'(CA_CMD))  cmd_q  <= cfg_wdata;
      if (cfg_addr == CFG_AW'(CA_BASE)) base_q <= cfg_wdata;
      if (cfg_addr == CFG_AW'(CA_IOB2)) iob2_q <= cfg_wdata;
      if (cfg_addr == CFG_AW'(CA_WCTL)) wctl_q <= cfg_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      if (cfg_addr == CFG_AW'(CA_CMD))       cfg_rdata <= cmd_q;
      else if (cfg_addr == CFG_AW'(CA_BASE)) cfg_rdata <= base_q;
      else if (cfg_addr == CFG_AW'(CA_IOB2)) cfg_rdata <= iob2_q;
      else if (cfg_addr == CFG_AW'(CA_WCTL)) cfg_rdata <= {24'h0, wctl_q};
      else                                   cfg_rdata <= '0;
    end
  end

  assign base_sel = base_q[IO_AW-1:WIN_AW];
  assign win_en   = wctl_q[0];
endmodule

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
  parameter int IO_AW  = 16,
  parameter int WIN_AW = 6,
  localparam int SEL_W = IO_AW - WIN_AW,
  localparam int OFW   = WIN_AW - 1
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic [SEL_W-1:0] base_sel,
  input  logic             win_en,
  output logic             hit,
  output logic [OFW-1:0]   word_ofs
);
  logic unused_lsb;
  assign unused_lsb = io_addr[0];
  assign hit      = win_en && (io_addr[IO_AW-1:WIN_AW] == base_sel);
  assign word_ofs = io_addr[WIN_AW-1:1];
endmodule

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  output logic [TMR_W-1:0] count,
  output logic             msb_flip
);
  logic msb_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      msb_prev_q <= 1'b0;
    end else begin
      count      <= count + TMR_W'(1);
      msb_prev_q <= count[TMR_W-1];
    end
  end

  assign msb_flip = count[TMR_W-1] ^ msb_prev_q;
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sts,
  input  logic             wr_en,
  input  logic [PM1_W-1:0] wdata,
  input  logic [PM1_W-1:0] ev_set,
  output logic [PM1_W-1:0] sts_q,
  output logic [PM1_W-1:0] en_q,
  output logic             sci,
  output logic             tmr_arm
);
  logic [PM1_W-1:0] sts_d, en_d;

  for (genvar b = 0; b < PM1_W; b++) begin : g_sts
    // a set on the same edge as a clear is kept
    assign sts_d[b] = ev_set[b] | (sts_q[b] & ~(wr_sts & wdata[b]));
  end

  assign en_d = wr_en ? wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= '0;
      en_q    <= '0;
      sci     <= 1'b0;
      tmr_arm <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      en_q    <= en_d;
      sci     <= |(sts_d & en_d & SCI_MASK);
      tmr_arm <= en_d[BIT_TMR] & ~sts_d[BIT_TMR];
    end
  end
endmodule

// File: rtl/pm_evt_sci.sv
module pm_evt_sci
  import pm_evt_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int IO_AW  = 16,
  parameter int WIN_AW = 6,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [15:0]       io_wdata,
  output logic [15:0]       io_rdata,
  input  logic [15:0]       ev_in,
  output logic              sci,
  output logic              tmr_arm
);
  localparam int SEL_W = IO_AW - WIN_AW;
  localparam int OFW   = WIN_AW - 1;

  logic [SEL_W-1:0] base_sel;
  logic             win_en, win_hit;
  logic [OFW-1:0]   word_ofs;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_flip;
  logic [PM1_W-1:0] sts_q, en_q, ev_set;
  logic [31:0]      tmr_ext;
  logic             wr_sts, wr_en;

  pm_cfg_regs #(.CFG_AW(CFG_AW), .IO_AW(IO_AW), .WIN_AW(WIN_AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .base_sel(base_sel), .win_en(win_en)
  );

  pm_win_decode #(.IO_AW(IO_AW), .WIN_AW(WIN_AW)) u_dec (
    .io_addr(io_addr), .base_sel(base_sel), .win_en(win_en),
    .hit(win_hit), .word_ofs(word_ofs)
  );

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .count(tmr_cnt), .msb_flip(tmr_flip)
  );

  assign wr_sts = io_wr && win_hit && (word_ofs == OFW'(WI_STS));
  assign wr_en  = io_wr && win_hit && (word_ofs == OFW'(WI_EN));
  assign ev_set = ev_in | (PM1_W'(tmr_flip) << BIT_TMR);

  pm1_evt_regs u_evt (
    .clk(clk), .rst(rst), .wr_sts(wr_sts), .wr_en(wr_en),
    .wdata(io_wdata), .ev_set(ev_set), .sts_q(sts_q), .en_q(en_q),
    .sci(sci), .tmr_arm(tmr_arm)
  );

  always_comb begin
    tmr_ext = '0;
    tmr_ext[TMR_W-1:0] = tmr_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= MISS_DATA;
    end else if (io_rd) begin
      if (!win_hit)                          io_rdata <= MISS_DATA;
      else if (word_ofs == OFW'(WI_STS))     io_rdata <= sts_q;
      else if (word_ofs == OFW'(WI_EN))      io_rdata <= en_q;
      else if (word_ofs == OFW'(WI_TLO))     io_rdata <= tmr_ext[15:0];
      else if (word_ofs == OFW'(WI_THI))     io_rdata <= tmr_ext[31:16];
      else                                   io_rdata <= '0;
    end
  end
endmodule

// File: rtl/pm_evt_sci_chk.sv
module pm_evt_sci_chk
  import pm_evt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             io_rd,
  input logic             io_wr,
  input logic             win_hit,
  input logic [15:0]      ev_in,
  input logic [15:0]      io_rdata,
  input logic [PM1_W-1:0] sts_q,
  input logic [PM1_W-1:0] en_q,
  input logic             sci,
  input logic             tmr_arm
);
  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !win_hit) |=> (io_rdata == 16'hFFFF)); // R3

  AST_MISS_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && win_hit) |=> $stable(en_q)); // R3

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|ev_in) |=> ((sts_q & $past(ev_in)) == $past(ev_in))); // R5

  AST_SCI_LEVEL: assert property (@(posedge clk) disable iff (rst)
    sci == (|(sts_q & en_q & SCI_MASK))); // R7

  AST_NO_STRAY_SCI: assert property (@(posedge clk) disable iff (rst)
    ((sts_q & en_q & SCI_MASK) == '0) |-> !sci); // R8

  AST_ARM_RULE: assert property (@(posedge clk) disable iff (rst)
    tmr_arm == (en_q[BIT_TMR] && !sts_q[BIT_TMR])); // R10
endmodule

bind pm_evt_sci pm_evt_sci_chk u_chk (
  .clk(clk), .rst(rst), .io_rd(io_rd), .io_wr(io_wr), .win_hit(win_hit),
  .ev_in(ev_in), .io_rdata(io_rdata), .sts_q(sts_q), .en_q(en_q),
  .sci(sci), .tmr_arm(tmr_arm)
);

// File: tb/sim_pm_evt_sci.sv
module sim_pm_evt_sci;
  localparam int TW = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic [15:0] ev_in = '0;
  logic        sci, tmr_arm;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pm_evt_sci #(.TMR_W(TW)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .ev_in(ev_in), .sci(sci), .tmr_arm(tmr_arm)
  );

  // {is_write, addr, data/expected, compare mask}; window base 0x4000
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 16'h4002, 16'hA5A5, 16'hFFFF},
    {1'b0, 16'h4002, 16'hA5A5, 16'hFFFF},
    {1'b0, 16'h4003, 16'hA5A5, 16'hFFFF},
    {1'b1, 16'h4002, 16'h0000, 16'hFFFF},
    {1'b0, 16'h4002, 16'h0000, 16'hFFFF},
    {1'b0, 16'h4004, 16'h0000, 16'hFFFF},
    {1'b0, 16'h403E, 16'h0000, 16'hFFFF},
    {1'b0, 16'h4040, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h3FFE, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h4040, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h4002, 16'h0000, 16'hFFFF},
    {1'b0, 16'h400A, 16'h0000, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_rd = 1'b0; d = cfg_rdata;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic pulse(input int b);
    @(negedge clk); ev_in = 16'h0; ev_in[b] = 1'b1;
    @(negedge clk); ev_in = 16'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    logic [15:0] r, t1, t2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 sci", 32'(sci), 32'd0);
    chk("R1 tmr_arm", 32'(tmr_arm), 32'd0);
    cfg_read(8'h04, c); chk("R1 cmd", c, 32'h0);
    cfg_read(8'h48, c); chk("R1 iobase2", c, 32'h1);
    cfg_read(8'h40, c); chk("R1 base", c, 32'h0);
    cfg_read(8'h80, c); chk("R1 wctl", c, 32'h0);
    cfg_read(8'h10, c); chk("R11 unmapped", c, 32'h0);
    io_read(16'h0002, r); chk("R3 disabled read", 32'(r), 32'hFFFF);

    cfg_write(8'h40, 32'h0000_4000);
    cfg_write(8'h80, 32'h0000_0001);
    cfg_read(8'h40, c); chk("R11 base readback", c, 32'h4000);

    // vector table: R4 R6 R3
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) io_write(VEC[i][47:32], VEC[i][31:16]);
      else begin
        io_read(VEC[i][47:32], r);
        chk($sformatf("R4/R6/R3 vector %0d", i), 32'(r & VEC[i][15:0]),
            32'(VEC[i][31:16] & VEC[i][15:0]));
      end
    end

    // R8 non-qualified source does not raise sci
    io_write(16'h4000, 16'hFFFF);
    io_write(16'h4002, 16'h0002);
    pulse(1);
    chk("R8 sci stays low", 32'(sci), 32'd0);
    io_read(16'h4000, r); chk("R5 event sets bit", 32'(r & 16'hFFFE), 32'h0002);

    // R7 power button
    io_write(16'h4002, 16'h0100);
    io_write(16'h4000, 16'hFFFF);
    pulse(8);
    chk("R7 power button sci", 32'(sci), 32'd1);
    io_write(16'h4000, 16'h0100);
    chk("R5 w1c drops sci", 32'(sci), 32'd0);

    // R5 set wins over clear on the same edge (RTC bit 10)
    io_write(16'h4002, 16'h0400);
    pulse(10);
    @(negedge clk);
    io_wr = 1'b1; io_addr = 16'h4000; io_wdata = 16'h0400; ev_in = 16'h0400;
    @(negedge clk);
    io_wr = 1'b0; ev_in = 16'h0;
    io_read(16'h4000, r); chk("R5 set beats clear", 32'(r & 16'h0400), 32'h0400);
    chk("R7 rtc sci", 32'(sci), 32'd1);
    io_write(16'h4000, 16'h0000);
    chk("R5 zero write keeps", 32'(sci), 32'd1);
    io_write(16'h4000, 16'h0400);

    // R7 global lock
    io_write(16'h4002, 16'h0020);
    pulse(5);
    chk("R7 global lock sci", 32'(sci), 32'd1);
    io_write(16'h4000, 16'h0020);

    // R2 relocation with low base bits set
    cfg_write(8'h40, 32'h0000_807F);
    io_read(16'h8042, r); chk("R2 relocated hit", 32'(r), 32'h0020);
    io_read(16'h4002, r); chk("R2 old base miss", 32'(r), 32'hFFFF);

    // R2/R3 disable gate
    cfg_write(8'h80, 32'h0);
    io_write(16'h8042, 16'h1234);
    io_read(16'h8042, r); chk("R3 disabled read", 32'(r), 32'hFFFF);
    cfg_write(8'h80, 32'h1);
    io_read(16'h8042, r); chk("R3 disabled write ignored", 32'(r), 32'h0020);

    // R9 timer counts every clock
    io_read(16'h8048, t1);
    io_read(16'h8048, t2);
    chk("R9 timer step", 32'((t2 - t1) & 16'h03FF), 32'd2);

    // R10 / R9 timer overflow and arming
    io_write(16'h8042, 16'h0001);
    io_write(16'h8040, 16'hFFFF);
    chk("R10 armed", 32'(tmr_arm), 32'd1);
    for (int k = 0; k < 1200 && !sci; k++) @(negedge clk);
    chk("R9 overflow raises sci", 32'(sci), 32'd1);
    chk("R10 disarmed while set", 32'(tmr_arm), 32'd0);
    io_read(16'h8040, r); chk("R9 status bit 0", 32'(r & 16'h0001), 32'h1);
    io_write(16'h8040, 16'h0001);
    chk("R10 rearmed", 32'(tmr_arm), 32'd1);
    chk("R7 sci cleared", 32'(sci), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule